// File: doc/BRIEF.md
# Vector Condition-Field Branch Evaluator

This block decides whether a vectorised conditional branch is taken. A bank of 128 four-bit condition fields arrives as one flat input. The block tests one selected bit from each element's field against an expected sense. It makes one such test per clock cycle.

A 5-bit bit-select operand is split in two. The low two bits pick the bit inside a field. The upper three bits are widened by a 4-bit extension, arranged one way for scalar operation and another way for vector operation, to form a 7-bit field index.

Two decision policies are supported:

- **First-success:** the branch is taken on the first passing element.
- **All-must-pass:** the branch is taken only if no participating element fails.

A predicate mask selects the participating elements. A masked-out element is either skipped, or replaced by a fixed substitute bit. In the length-setting modes, the block also returns a vector length truncated at the element that decided the outcome.

The condition-field input must stay stable from the start pulse until done.

Top module: `vbranch_eval`

## Requirements
- R1: Field `k` occupies `cr_i[4k+3:4k]`. The upper three bits of `bi_i` are called `top`. In scalar mode (`vec_i=0`) every element tests field `{ext_i, top}`. In vector mode, element `i` tests field `({top, ext_i} + i) mod 128`.
- R2: `bi_i[1:0]` selects the tested bit within a field. A value of 0 selects field bit 3 and a value of 3 selects field bit 0. An element passes when the tested bit equals `sense_i`.
- R3: With the all-flag `mode_i[3]=0`, the branch is taken at the first participating element that passes. It is not taken if none passes.
- R4: With `mode_i[3]=1`, the branch is not taken at the first participating element that fails. It is taken if none fails.
- R5: When `mode_i[4]=1` (zeroing), an element whose mask bit is 0 still participates, with a tested bit equal to the substitute bit. The substitute bit is `mode_i[2]` when `mode_i[0]=0`, and 0 when `mode_i[0]=1`.
- R6: When `mode_i[4]=0`, elements whose mask bit is 0 are skipped and never decide the outcome.
- R7: The length-setting modes are those with `mode_i[0]=1`. In these modes, when element `i` decides, `vl_o` is `i+1` if `mode_i[2]=1` and `i` otherwise. In every other case `vl_o` equals `vl_i`.
- R8: If `vf_i=1` and `mode_i[3]=1` at start, `err_o` is 1 and the branch is not taken. Done arrives one cycle after start, and `vl_o` equals `vl_i`. Otherwise `err_o` is 0.
- R9: A vector length of 0 completes one cycle after start, with `taken_o` equal to `mode_i[3]`.
- R10: Reset clears all outputs. The done pulse lasts one cycle and arrives at a fixed delay after the start edge:
  - `k+2` cycles when element `k` decides;
  - `vl_i+1` cycles when no element decides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; ignored while a scan runs |
| cr_i | input | 512 | 128 condition fields, 4 bits each |
| bi_i | input | 5 | Bit-select operand |
| ext_i | input | 4 | Field-index extension |
| vec_i | input | 1 | 1 = vector, 0 = scalar |
| vl_i | input | 7 | Vector length, 0 to 64 (larger values are treated as 64) |
| mask_i | input | 64 | Predicate mask, bit i for element i |
| mode_i | input | 5 | [1:0] kind, [2] substitute/inclusive bit, [3] all, [4] zeroing |
| sense_i | input | 1 | Expected bit value |
| vf_i | input | 1 | Vertical-first flag |
| taken_o | output | 1 | Branch outcome |
| done_o | output | 1 | One-cycle completion pulse |
| vl_o | output | 7 | Resulting vector length |
| err_o | output | 1 | Undefined combination flag |

## Verification
All results become visible together with the done pulse. Done is due one cycle after the start edge for the error and zero-length cases, `k+2` cycles after it when element `k` decides, and `vl_i+1` cycles after it when the scan runs out. The bench drives start on a falling edge and counts falling edges until done rises. It compares that count with the latency its own model predicts for the case, then samples the outcome, length and error outputs in that same cycle. On the following falling edge it confirms that done has dropped.

// File: rtl/vbe_pkg.sv
package vbe_pkg;
  localparam int FIDX_W   = 7;
  localparam int N_FIELDS = 1 << FIDX_W;
  localparam int FIELD_W  = 4;
  localparam int CR_W     = N_FIELDS * FIELD_W;

  typedef enum logic [1:0] {
    K_NORMAL    = 2'b00,
    K_VLSET     = 2'b01,
    K_STEP      = 2'b10,
    K_STEP_VLSET = 2'b11
  } kind_e;

  typedef struct packed {
    logic  zero;
    logic  all;
    logic  b2;
    kind_e kind;
  } mode_t;

  typedef enum logic {ST_IDLE, ST_SCAN} state_e;
endpackage

// File: rtl/vbe_elem_test.sv
module vbe_elem_test
  import vbe_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int ELW = $clog2(MAX_VL)
) (
  input  logic [CR_W-1:0] cr_i,
  input  logic [4:0]      bi_i,
  input  logic [3:0]      ext_i,
  input  logic            vec_i,
  input  logic [ELW-1:0]  elem_i,
  input  logic            pred_i,
  input  logic            zero_i,
  input  logic            subst_i,
  input  logic            sense_i,
  output logic            active_o,
  output logic            pass_o
);
  logic [FIDX_W-1:0]   base;
  logic [FIDX_W-1:0]   idx;
  logic [FIDX_W+1:0]   lsb;
  logic [FIELD_W-1:0]  fld;
  logic                tbit;

  always_comb begin
    base = vec_i ? {bi_i[4:2], ext_i} : {ext_i, bi_i[4:2]};
    idx  = vec_i ? base + FIDX_W'(elem_i) : base;
    lsb  = {idx, 2'b00};
    fld  = cr_i[lsb +: FIELD_W];
    // bit 0 of the selector names the field's top bit
    tbit = pred_i ? fld[~bi_i[1:0]] : subst_i;
    active_o = pred_i | zero_i;
    pass_o   = (tbit == sense_i);
  end
endmodule

// File: rtl/vbe_scan_ctrl.sv
module vbe_scan_ctrl
  import vbe_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int VLW = $clog2(MAX_VL + 1),
  localparam int ELW = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [4:0]        bi_i,
  input  logic [3:0]        ext_i,
  input  logic              vec_i,
  input  logic [VLW-1:0]    vl_i,
  input  logic [MAX_VL-1:0] mask_i,
  input  logic [4:0]        mode_i,
  input  logic              sense_i,
  input  logic              vf_i,
  input  logic              active_i,
  input  logic              pass_i,
  output logic [4:0]        bi_o,
  output logic [3:0]        ext_o,
  output logic              vec_o,
  output logic [ELW-1:0]    elem_o,
  output logic              pred_o,
  output logic              zero_o,
  output logic              subst_o,
  output logic              sense_o,
  output logic              taken_o,
  output logic              done_o,
  output logic [VLW-1:0]    vl_o,
  output logic              err_o
);
  mode_t mode_in;
  assign mode_in = mode_t'(mode_i);

  state_e            state_q, state_d;
  logic [ELW-1:0]    elem_q, elem_d;
  logic [VLW-1:0]    vl_q, vl_cap;
  logic [MAX_VL-1:0] mask_q;
  logic [4:0]        bi_q;
  logic [3:0]        ext_q;
  logic              vec_q, vlset_q, b2_q, all_q, zero_q, sense_q;
  logic              taken_q, taken_d, done_q, done_d, err_q, err_d;
  logic [VLW-1:0]    vlout_q, vlout_d;
  logic              cap_en, last, decide;

  assign vl_cap = (vl_i > VLW'(MAX_VL)) ? VLW'(MAX_VL) : vl_i;
  assign last   = (VLW'(elem_q) == (vl_q - VLW'(1)));
  assign decide = active_i & (all_q ? ~pass_i : pass_i);

  always_comb begin
    state_d = state_q;
    elem_d  = elem_q;
    taken_d = taken_q;
    vlout_d = vlout_q;
    err_d   = err_q;
    done_d  = 1'b0;
    cap_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cap_en  = 1'b1;
          elem_d  = '0;
          err_d   = 1'b0;
          vlout_d = vl_cap;
          if (vf_i && mode_in.all) begin
            err_d   = 1'b1;
            taken_d = 1'b0;
            done_d  = 1'b1;
          end else if (vl_cap == '0) begin
            taken_d = mode_in.all;
            done_d  = 1'b1;
          end else begin
            state_d = ST_SCAN;
          end
        end
      end
      default: begin
        if (decide) begin
          taken_d = ~all_q;
          done_d  = 1'b1;
          state_d = ST_IDLE;
          if (vlset_q) vlout_d = VLW'(elem_q) + VLW'(b2_q);
        end else if (last) begin
          taken_d = all_q;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          elem_d = elem_q + ELW'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      elem_q  <= '0;
      taken_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      vlout_q <= '0;
    end else begin
      state_q <= state_d;
      elem_q  <= elem_d;
      taken_q <= taken_d;
      done_q  <= done_d;
      err_q   <= err_d;
      vlout_q <= vlout_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q    <= '0;
      mask_q  <= '0;
      bi_q    <= '0;
      ext_q   <= '0;
      vec_q   <= 1'b0;
      vlset_q <= 1'b0;
      b2_q    <= 1'b0;
      all_q   <= 1'b0;
      zero_q  <= 1'b0;
      sense_q <= 1'b0;
    end else if (cap_en) begin
      vl_q    <= vl_cap;
      mask_q  <= mask_i;
      bi_q    <= bi_i;
      ext_q   <= ext_i;
      vec_q   <= vec_i;
      vlset_q <= mode_in.kind[0];
      b2_q    <= mode_in.b2;
      all_q   <= mode_in.all;
      zero_q  <= mode_in.zero;
      sense_q <= sense_i;
    end
  end

  assign bi_o    = bi_q;
  assign ext_o   = ext_q;
  assign vec_o   = vec_q;
  assign elem_o  = elem_q;
  assign pred_o  = mask_q[elem_q];
  assign zero_o  = zero_q;
  assign subst_o = ~vlset_q & b2_q;
  assign sense_o = sense_q;
  assign taken_o = taken_q;
  assign done_o  = done_q;
  assign vl_o    = vlout_q;
  assign err_o   = err_q;

  // R8
  err_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && err_q) |-> !taken_q);
  // R7
  vl_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (vlout_q <= vl_q));
  // R7
  vl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !vlset_q) |-> (vlout_q == vl_q));
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == ST_IDLE));
  // R10
  scan_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN) |-> (VLW'(elem_q) < vl_q));
  // R10
  scan_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_SCAN) |-> $past(start_i));
endmodule

// File: rtl/vbranch_eval.sv
module vbranch_eval
  import vbe_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int VLW = $clog2(MAX_VL + 1),
  localparam int ELW = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CR_W-1:0]   cr_i,
  input  logic [4:0]        bi_i,
  input  logic [3:0]        ext_i,
  input  logic              vec_i,
  input  logic [VLW-1:0]    vl_i,
  input  logic [MAX_VL-1:0] mask_i,
  input  logic [4:0]        mode_i,
  input  logic              sense_i,
  input  logic              vf_i,
  output logic              taken_o,
  output logic              done_o,
  output logic [VLW-1:0]    vl_o,
  output logic              err_o
);
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  logic [4:0]     s_bi;
  logic [3:0]     s_ext;
  logic           s_vec, s_pred, s_zero, s_subst, s_sense, s_active, s_pass;
  logic [ELW-1:0] s_elem;

  vbe_scan_ctrl #(.MAX_VL(MAX_VL)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (start_i),
    .bi_i     (bi_i),
    .ext_i    (ext_i),
    .vec_i    (vec_i),
    .vl_i     (vl_i),
    .mask_i   (mask_i),
    .mode_i   (mode_i),
    .sense_i  (sense_i),
    .vf_i     (vf_i),
    .active_i (s_active),
    .pass_i   (s_pass),
    .bi_o     (s_bi),
    .ext_o    (s_ext),
    .vec_o    (s_vec),
    .elem_o   (s_elem),
    .pred_o   (s_pred),
    .zero_o   (s_zero),
    .subst_o  (s_subst),
    .sense_o  (s_sense),
    .taken_o  (taken_o),
    .done_o   (done_o),
    .vl_o     (vl_o),
    .err_o    (err_o)
  );

  vbe_elem_test #(.MAX_VL(MAX_VL)) u_test (
    .cr_i     (cr_i),
    .bi_i     (s_bi),
    .ext_i    (s_ext),
    .vec_i    (s_vec),
    .elem_i   (s_elem),
    .pred_i   (s_pred),
    .zero_i   (s_zero),
    .subst_i  (s_subst),
    .sense_i  (s_sense),
    .active_o (s_active),
    .pass_o   (s_pass)
  );
endmodule

// File: tb/tb_vbranch_eval.sv
`timescale 1ns/1ps
module tb_vbranch_eval;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [511:0] cr_i = '0;
  logic [4:0]   bi_i = '0;
  logic [3:0]   ext_i = '0;
  logic         vec_i = 1'b0;
  logic [6:0]   vl_i = '0;
  logic [63:0]  mask_i = '0;
  logic [4:0]   mode_i = '0;
  logic         sense_i = 1'b0;
  logic         vf_i = 1'b0;
  logic         taken_o, done_o, err_o;
  logic [6:0]   vl_o;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  vbranch_eval dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cr_i(cr_i), .bi_i(bi_i),
    .ext_i(ext_i), .vec_i(vec_i), .vl_i(vl_i), .mask_i(mask_i),
    .mode_i(mode_i), .sense_i(sense_i), .vf_i(vf_i),
    .taken_o(taken_o), .done_o(done_o), .vl_o(vl_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void model(
    input logic [511:0] cr, input logic [4:0] bi, input logic [3:0] ext,
    input logic vec, input logic [6:0] vl, input logic [63:0] mask,
    input logic [4:0] mode, input logic sense, input logic vf,
    output logic taken, output logic [6:0] nvl, output logic err, output int lat);
    logic all, zero, vlset, subst, vli, b;
    logic [6:0] base, fi;
    all = mode[3]; zero = mode[4]; vlset = mode[0];
    subst = ~mode[0] & mode[2]; vli = mode[0] & mode[2];
    err = 1'b0; nvl = vl;
    if (vf && all) begin taken = 1'b0; err = 1'b1; lat = 1; return; end
    if (vl == 0) begin taken = all; lat = 1; return; end
    taken = all; lat = int'(vl) + 1;
    base = vec ? {bi[4:2], ext} : {ext, bi[4:2]};
    for (int i = 0; i < int'(vl); i++) begin
      fi = vec ? base + 7'(i) : base;
      if (mask[i]) b = cr[int'(fi) * 4 + 3 - int'(bi[1:0])];
      else if (zero) b = subst;
      else continue;
      if (all ? (b != sense) : (b == sense)) begin
        taken = ~all; lat = i + 2;
        if (vlset) nvl = 7'(i) + 7'(vli);
        return;
      end
    end
  endfunction

  task automatic run_case(input string tag, input logic [511:0] cr,
    input logic [4:0] bi, input logic [3:0] ext, input logic vec,
    input logic [6:0] vl, input logic [63:0] mask, input logic [4:0] mode,
    input logic sense, input logic vf);
    logic et, ee; logic [6:0] ev; int lat; int cyc;
    model(cr, bi, ext, vec, vl, mask, mode, sense, vf, et, ev, ee, lat);
    @(negedge clk);
    cr_i = cr; bi_i = bi; ext_i = ext; vec_i = vec; vl_i = vl; mask_i = mask;
    mode_i = mode; sense_i = sense; vf_i = vf; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == lat, {tag, " R10 latency"}, cyc, lat);
    chk(taken_o == et, tag, int'(taken_o), int'(et));
    chk(vl_o == ev, "R7 length", int'(vl_o), int'(ev));
    chk(err_o == ee, "R8 error", int'(err_o), int'(ee));
    @(negedge clk);
    chk(done_o == 1'b0, "R10 done width", int'(done_o), 0);
  endtask

  function automatic logic [511:0] rand_cr();
    logic [511:0] v;
    for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    logic [511:0] c;
    logic [63:0]  m;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done_o == 0 && taken_o == 0 && err_o == 0 && vl_o == 0,
        "R10 reset", int'({done_o, taken_o, err_o}), 0);

    // R1 vector: base {010,0101}=37, element 2 hits field 39 top bit
    c = '0; c[39*4 + 3] = 1'b1;
    run_case("R1 vector index", c, 5'b010_00, 4'h5, 1'b1, 7'd8, '1, 5'b00000, 1'b1, 1'b0);
    // R1 vector wrap from field 127 to 0
    c = '0; c[0*4 + 3] = 1'b1;
    run_case("R1 wrap", c, 5'b111_00, 4'hF, 1'b1, 7'd4, '1, 5'b00000, 1'b1, 1'b0);
    // R1 scalar: field {0101,010}=42
    c = '0; c[42*4 + 3] = 1'b1;
    run_case("R1 scalar", c, 5'b010_00, 4'h5, 1'b0, 7'd3, '1, 5'b00000, 1'b1, 1'b0);
    // R2 selector 3 picks field bit 0
    c = '0; c[42*4] = 1'b1;
    run_case("R2 bit pick", c, 5'b010_11, 4'h5, 1'b0, 7'd3, '1, 5'b00000, 1'b1, 1'b0);
    run_case("R2 bit miss", c, 5'b010_10, 4'h5, 1'b0, 7'd3, '1, 5'b00000, 1'b1, 1'b0);
    // R3 no success over full length
    run_case("R3 none", '0, 5'd0, 4'd0, 1'b1, 7'd64, '1, 5'b00000, 1'b1, 1'b0);
    // R4 all pass over full length
    run_case("R4 all pass", '0, 5'd0, 4'd0, 1'b1, 7'd64, '1, 5'b01000, 1'b0, 1'b0);
    // R5 substitute bit 1 in normal kind, all masked
    run_case("R5 subst all", '0, 5'd0, 4'd0, 1'b1, 7'd10, '0, 5'b11100, 1'b1, 1'b0);
    run_case("R5 subst first", '0, 5'd0, 4'd0, 1'b1, 7'd10, '0, 5'b10100, 1'b1, 1'b0);
    // R5 substitute is 0 in length-setting kind
    run_case("R5 subst vlset", '0, 5'd0, 4'd0, 1'b1, 7'd10, '0, 5'b10101, 1'b0, 1'b0);
    // R6 masked elements skipped
    run_case("R6 skip any", '1, 5'd0, 4'd0, 1'b1, 7'd10, '0, 5'b00000, 1'b1, 1'b0);
    run_case("R6 skip all", '0, 5'd0, 4'd0, 1'b1, 7'd10, '0, 5'b01000, 1'b1, 1'b0);
    // R7 truncation inclusive and exclusive, decided at element 5
    c = '0; c[5*4 + 3] = 1'b1;
    run_case("R7 inclusive", c, 5'd0, 4'd0, 1'b1, 7'd20, '1, 5'b00101, 1'b1, 1'b0);
    run_case("R7 exclusive", c, 5'd0, 4'd0, 1'b1, 7'd20, '1, 5'b00011, 1'b1, 1'b0);
    // R8 vertical-first with all
    run_case("R8 undefined", '1, 5'd0, 4'd0, 1'b1, 7'd20, '1, 5'b01001, 1'b1, 1'b1);
    // R9 zero length
    run_case("R9 len0 any", '1, 5'd0, 4'd0, 1'b1, 7'd0, '1, 5'b00000, 1'b1, 1'b0);
    run_case("R9 len0 all", '0, 5'd0, 4'd0, 1'b1, 7'd0, '1, 5'b01000, 1'b1, 1'b0);

    for (int t = 0; t < 400; t++) begin
      logic [4:0] md;
      c = rand_cr();
      if ($urandom_range(0, 1) == 1) c = c & rand_cr() & rand_cr();
      m = {$urandom, $urandom};
      if ($urandom_range(0, 2) == 0) m = m & {$urandom, $urandom};
      md = 5'($urandom);
      run_case(md[3] ? "R4 random" : "R3 random", c, 5'($urandom), 4'($urandom),
               1'($urandom), 7'($urandom_range(0, 64)), m, md, 1'($urandom),
               ($urandom_range(0, 9) == 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    nchk++; nerr++;
    $display("FAIL R10 watchdog: got %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule